// File: doc/BRIEF.md
# Delayed-Reply SPI Register Slave

This block is a 16-bit SPI slave in front of a small register file. Each frame brings in one command word: bit 0 selects write (1) or read (0), bits 7:1 give a 7-bit register address, and bits 15:8 carry the write datum. The answer to a command is not returned in the frame that carries it. It is shifted back on MISO during the following frame as one 16-bit word with the same field layout: the access bit, the address, and the content of the register that the previous command selected.

The register file holds a parameterised bank of 8-bit configuration registers starting at address 0x40, with 8 registers by default. Their contents are presented in parallel to the rest of the chip. Four further addresses control the bank and report on it:
- 0x1A is a software-reset trigger, with key 0x03.
- 0x1C is the output-enable command: 0x02 sets the enable and 0x01 clears it.
- 0x1E is the lock command: 0x01 releases the lock and 0x02 sets it.
- 0x35 is a read-only status byte whose bit 6 mirrors the output enable.

The SPI pins are brought into the system clock domain through synchronisers, and all decoding runs on the system clock. The system clock must be several times faster than SCLK.

Top module: `spi_regslave`

## Requirements
- R1: Frames are 16 bits, shifted MSB first in SPI mode 1. The slave samples MOSI on the falling SCLK edge and changes MISO on the rising edge. The frame is committed when CS_n rises. Command and reply words both use the layout bit 0 = write flag, bits 7:1 = address, bits 15:8 = data.
- R2: The reply to a command is shifted out during the next frame. After reset the reply word is 0x0000, all configuration registers are 0 and the output enable is 0.
- R3: A write to a configuration address (0x40 up to 0x40+NUM_CFG-1) while the bank is unlocked stores the datum. The reply is bit 0 = 1, the address, and the stored datum.
- R4: A read of a configuration address returns bit 0 = 0, the address, and the register content.
- R5: For an unmapped address, a write to the status address 0x35, or a read of any write-only command address (0x1A, 0x1C, 0x1E), the reply echoes the access bit and the address with data 0x00, and no state changes.
- R6: The bank is locked out of reset. Writing 0x01 to 0x1E unlocks it and writing 0x02 locks it. While locked, configuration writes leave the registers unchanged, and the reply carries the unchanged content.
- R7: Writing 0x02 to 0x1C sets the output enable and writing 0x01 clears it. The enable drives port out_en and reads back as bit 6 of address 0x35, with the other bits 0.
- R8: Writing 0x03 to 0x1A clears all configuration registers and the output enable and re-locks the bank. The next frame returns 0x0035: write bit set, address 0x1A, data 0.
- R9: A frame with any count of SCLK falling edges other than 16 is discarded. Register state and the pending reply stay unchanged, so the next frame returns the same reply again.
- R10: MISO is held low while CS_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial reply data to the master |
| cfg_regs | output | NUM_CFG*8 | Configuration register contents, register i in bits 8i+7:8i |
| out_en | output | 1 | Global output-enable bit |

## Verification
The checker watches several properties on every cycle:
- the pending reply, the configuration bank and the enable change only when a complete frame commits;
- a locked configuration write leaves the bank untouched;
- a software reset leaves the cleared state and the 0x0035 echo one cycle later;
- MISO stays low whenever chip select is idle.

Other behaviour can only be shown by the bench's frame sequences:
- the one-frame delay of every reply;
- the bit order and edge usage of the serial format;
- zero data for unmapped and wrong-direction accesses;
- the repeat of the old reply after a truncated or overlong frame.

These sequences are checked against a bench-side register model over directed chains and seeded random traffic.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;

  // Command and reply word: data in 15:8, address in 7:1, write flag in bit 0
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    logic              wr;
  } cmd_t;

  localparam logic [ADDR_W-1:0] ADDR_SRST = 7'h1A;
  localparam logic [ADDR_W-1:0] ADDR_OE   = 7'h1C;
  localparam logic [ADDR_W-1:0] ADDR_LOCK = 7'h1E;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 7'h35;

  localparam logic [DATA_W-1:0] SRST_KEY = 8'h03;
  localparam logic [DATA_W-1:0] CODE_ON  = 8'h02;
  localparam logic [DATA_W-1:0] CODE_OFF = 8'h01;
  localparam int                STAT_OE_BIT = 6;

  function automatic logic [FRAME_W-1:0] make_reply(input logic wr,
                                                    input logic [ADDR_W-1:0] addr,
                                                    input logic [DATA_W-1:0] data);
    cmd_t r;
    r.wr   = wr;
    r.addr = addr;
    r.data = data;
    return FRAME_W'(r);
  endfunction

  function automatic logic [DATA_W-1:0] status_byte(input logic oe);
    logic [DATA_W-1:0] s;
    s = '0;
    s[STAT_OE_BIT] = oe;
    return s;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain <= d_in[b];
      else chain <= {chain[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_regslave_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] reply,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] rx_word,
  output logic               miso
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam int CNT_W = BIT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_d, cs_d;
  logic               sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [CNT_W-1:0]   fall_cnt, rise_cnt;
  logic [FRAME_W-1:0] rx_sh;
  logic [BIT_W-1:0]   tx_idx;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~cs_n_s & cs_d;
  assign cs_rise   = cs_n_s & ~cs_d;
  assign tx_idx    = BIT_W'(FRAME_W - 1) - rise_cnt[BIT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= '0;
      rise_cnt <= '0;
      rx_sh    <= '0;
      miso     <= 1'b0;
    end else if (cs_n_s) begin
      miso <= 1'b0;
    end else if (cs_fall) begin
      fall_cnt <= '0;
      rise_cnt <= '0;
      rx_sh    <= '0;
      miso     <= 1'b0;
    end else begin
      if (sclk_fall) begin
        rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
        if (fall_cnt != CNT_MAX) fall_cnt <= fall_cnt + 1'b1;
      end
      if (sclk_rise) begin
        miso <= (rise_cnt < CNT_FULL) ? reply[tx_idx] : 1'b0;
        if (rise_cnt != CNT_MAX) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_ok <= 1'b0;
    else        frame_ok <= cs_rise && (fall_cnt == CNT_FULL);
  end

  assign rx_word = rx_sh;

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_regslave_pkg::*;
#(
  parameter int NUM_CFG  = 8,
  parameter int CFG_BASE = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  cmd_t                      cmd,
  output logic [NUM_CFG*DATA_W-1:0] cfg_regs,
  output logic                      out_en,
  output logic                      locked,
  output logic [FRAME_W-1:0]        reply,
  output logic                      cfg_wr_req,
  output logic                      srst_req
);

  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(NUM_CFG);

  logic [ADDR_W-1:0] offs;
  logic              cfg_hit;
  logic              ctl_wr;
  logic [DATA_W-1:0] cfg_q [NUM_CFG];
  logic [DATA_W-1:0] cfg_sel;
  logic [DATA_W-1:0] rdata;
  logic [NUM_CFG-1:0] cfg_we;

  assign offs       = cmd.addr - BASE_A;
  assign cfg_hit    = (cmd.addr >= BASE_A) && (offs < COUNT_A);
  assign ctl_wr     = commit && cmd.wr;
  assign cfg_wr_req = ctl_wr && cfg_hit;
  assign srst_req   = ctl_wr && (cmd.addr == ADDR_SRST) && (cmd.data == SRST_KEY);

  always_comb begin
    cfg_sel = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (offs == ADDR_W'(i)) cfg_sel = cfg_q[i];
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    assign cfg_we[g] = cfg_wr_req && !locked && (offs == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[g] <= '0;
      else if (srst_req)  cfg_q[g] <= '0;
      else if (cfg_we[g]) cfg_q[g] <= cmd.data;
    end
    assign cfg_regs[g*DATA_W +: DATA_W] = cfg_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      out_en <= 1'b0;
    end else if (srst_req) begin
      locked <= 1'b1;
      out_en <= 1'b0;
    end else if (ctl_wr) begin
      if (cmd.addr == ADDR_LOCK) begin
        if (cmd.data == CODE_OFF)     locked <= 1'b0;
        else if (cmd.data == CODE_ON) locked <= 1'b1;
      end
      if (cmd.addr == ADDR_OE) begin
        if (cmd.data == CODE_ON)       out_en <= 1'b1;
        else if (cmd.data == CODE_OFF) out_en <= 1'b0;
      end
    end
  end

  // Reply data: post-write content for configuration registers, status on read,
  // zero for everything else (unmapped, write-only, wrong direction)
  always_comb begin
    rdata = '0;
    if (cfg_hit)
      rdata = (cmd.wr && !locked) ? cmd.data : cfg_sel;
    else if (!cmd.wr && (cmd.addr == ADDR_STAT))
      rdata = status_byte(out_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reply <= '0;
    else if (commit) reply <= make_reply(cmd.wr, cmd.addr, rdata);
  end

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int NUM_CFG     = 8,
  parameter int CFG_BASE    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  output logic [NUM_CFG*DATA_W-1:0] cfg_regs,
  output logic                      out_en
);

  logic [2:0]         pins_s;
  logic               sclk_s, cs_high, mosi_s;
  logic               frame_ok;
  logic [FRAME_W-1:0] rx_word;
  logic [FRAME_W-1:0] reply_q;
  cmd_t               rx_cmd;
  logic               locked;
  logic               cfg_wr_req;
  logic               srst_req;

  spi_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({spi_mosi, spi_cs_n, spi_sclk}),
    .d_out (pins_s)
  );

  assign sclk_s  = pins_s[0];
  assign cs_high = pins_s[1];
  assign mosi_s  = pins_s[2];

  spi_frame_rx i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .cs_n_s   (cs_high),
    .mosi_s   (mosi_s),
    .reply    (reply_q),
    .frame_ok (frame_ok),
    .rx_word  (rx_word),
    .miso     (spi_miso)
  );

  assign rx_cmd = cmd_t'(rx_word);

  spi_regfile #(
    .NUM_CFG  (NUM_CFG),
    .CFG_BASE (CFG_BASE)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (frame_ok),
    .cmd        (rx_cmd),
    .cfg_regs   (cfg_regs),
    .out_en     (out_en),
    .locked     (locked),
    .reply      (reply_q),
    .cfg_wr_req (cfg_wr_req),
    .srst_req   (srst_req)
  );

endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
  parameter int NUM_CFG = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_ok,
  input logic [15:0]          reply_q,
  input logic                 cs_high,
  input logic                 spi_miso,
  input logic                 locked,
  input logic                 cfg_wr_req,
  input logic                 srst_req,
  input logic [NUM_CFG*8-1:0] cfg_regs,
  input logic                 out_en
);

  // R9
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(reply_q));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(cfg_regs));

  // R7
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(out_en));

  // R6
  lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_req && locked) |=> $stable(cfg_regs));

  // R8
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> (cfg_regs == '0) && !out_en && locked && (reply_q == 16'h0035));

  // R10
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !spi_miso);

endmodule

bind spi_regslave spi_regslave_chk #(.NUM_CFG(NUM_CFG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_ok   (frame_ok),
  .reply_q    (reply_q),
  .cs_high    (cs_high),
  .spi_miso   (spi_miso),
  .locked     (locked),
  .cfg_wr_req (cfg_wr_req),
  .srst_req   (srst_req),
  .cfg_regs   (cfg_regs),
  .out_en     (out_en)
);

// File: tb/test_spi_regslave.sv
`timescale 1ns/1ps
module test_spi_regslave;

  localparam int NCFG = 8;
  localparam logic [6:0] BASE = 7'h40;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic spi_miso;
  logic [NCFG*8-1:0] cfg_regs;
  logic out_en;

  int n_checks = 0;
  int n_fail = 0;

  // bench-side model
  logic [7:0] m_cfg [NCFG];
  logic       m_lock, m_oe;
  logic [15:0] m_reply;
  string      m_tag, prev_tag;

  always #2.5 clk = ~clk;

  spi_regslave i_spi_regslave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(spi_miso), .cfg_regs(cfg_regs), .out_en(out_en)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic wr, input logic [6:0] a, input logic [7:0] d);
    return {d, a, wr};
  endfunction

  function automatic logic [NCFG*8-1:0] model_flat();
    logic [NCFG*8-1:0] f;
    for (int i = 0; i < NCFG; i++) f[i*8 +: 8] = m_cfg[i];
    return f;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCFG; i++) m_cfg[i] = 8'h00;
    m_lock = 1'b1;
    m_oe   = 1'b0;
  endtask

  // applies one complete command to the model, sets m_reply and m_tag
  task automatic model_exec(input logic [15:0] c);
    logic wr; logic [6:0] a; logic [7:0] d; logic [7:0] rd;
    wr = c[0]; a = c[7:1]; d = c[15:8]; rd = 8'h00; m_tag = "R5";
    if (a >= BASE && a < BASE + 7'(NCFG)) begin
      if (wr) begin
        m_tag = m_lock ? "R6" : "R3";
        if (!m_lock) m_cfg[a - BASE] = d;
      end else m_tag = "R4";
      rd = m_cfg[a - BASE];
    end else if (a == 7'h35 && !wr) begin
      rd = {1'b0, m_oe, 6'b0}; m_tag = "R7";
    end else if (wr && a == 7'h1E) begin
      m_tag = "R6";
      if (d == 8'h01) m_lock = 1'b0; else if (d == 8'h02) m_lock = 1'b1;
    end else if (wr && a == 7'h1C) begin
      m_tag = "R7";
      if (d == 8'h02) m_oe = 1'b1; else if (d == 8'h01) m_oe = 1'b0;
    end else if (wr && a == 7'h1A && d == 8'h03) begin
      m_tag = "R8";
      model_reset();
    end
    m_reply = word(wr, a, rd);
  endtask

  task automatic xfer(input logic [15:0] tx, input int nclk, output logic [15:0] rx);
    rx = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 16) ? tx[15-i] : 1'b0;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 16) rx = {rx[14:0], spi_miso};
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // full frame: checks the delayed reply, then the parallel outputs
  task automatic frame(input logic [15:0] c);
    logic [15:0] rx;
    logic [15:0] exp;
    exp = m_reply;
    xfer(c, 16, rx);
    check(prev_tag, rx, exp, "delayed reply");
    model_exec(c);
    prev_tag = m_tag;
    check(m_tag, cfg_regs, model_flat(), "cfg_regs after frame");
    check(m_tag, out_en, m_oe, "out_en after frame");
  endtask

  task automatic bad_frame(input logic [15:0] c, input int n);
    logic [15:0] rx;
    xfer(c, n, rx);
    prev_tag = "R9";
    check("R9", cfg_regs, model_flat(), "cfg_regs after discarded frame");
    check("R9", out_en, m_oe, "out_en after discarded frame");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] rx;
    int k, n;
    void'($urandom(32'h5EED_1234));
    model_reset();
    m_reply = 16'h0000;
    prev_tag = "R2";
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R2", cfg_regs, '0, "cfg_regs after reset");
    check("R2", out_en, 1'b0, "out_en after reset");
    check("R10", spi_miso, 1'b0, "miso idle");

    frame(word(0, 7'h40, 8'h00));            // first reply 0x0000 (R2)
    frame(word(1, 7'h41, 8'h5A));            // locked write (R6)
    frame(word(1, 7'h1E, 8'h01));            // unlock
    frame(word(1, 7'h42, 8'hA5));            // R3
    xfer(word(0, 7'h42, 8'h00), 16, rx);     // R1: exact serial word of write echo
    check("R1", rx, 16'hA585, "MSB-first echo of write to 0x42");
    model_exec(word(0, 7'h42, 8'h00)); prev_tag = "R4";
    frame(word(0, 7'h7F, 8'h00));            // R4 reply for 0x42 read
    frame(word(0, 7'h1E, 8'h00));            // unmapped reply check
    frame(word(1, 7'h35, 8'hFF));            // wrong-direction reads of lock
    frame(word(1, 7'h1C, 8'h02));            // write to status ignored
    frame(word(0, 7'h35, 8'h00));            // oe set
    frame(word(1, 7'h1E, 8'h02));            // status read shows 0x40
    frame(word(1, 7'h42, 8'h11));            // relocked
    frame(word(0, 7'h42, 8'h00));            // write ignored (R6)
    bad_frame(word(1, 7'h43, 8'h77), 10);    // R9 short
    frame(word(0, 7'h42, 8'h00));            // reply repeats
    bad_frame(word(1, 7'h1C, 8'h01), 20);    // R9 long
    frame(word(1, 7'h1A, 8'h03));            // R8 software reset
    frame(word(0, 7'h42, 8'h00));            // reply 0x0035
    check("R8", m_reply, 16'h0084, "model sanity after reset read");

    for (int it = 0; it < 250; it++) begin
      k = $urandom_range(0, 11);
      case (k)
        0, 1, 2, 3: frame(word(1, BASE + 7'($urandom_range(0, NCFG-1)), 8'($urandom)));
        4, 5:       frame(word(0, BASE + 7'($urandom_range(0, NCFG-1)), 8'($urandom)));
        6:  frame(word(1, 7'h1E, ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(1, 2))));
        7:  frame(word(1'($urandom), 7'h1C, 8'($urandom_range(0, 3))));
        8:  frame(word(1'($urandom), 7'h35, 8'($urandom)));
        9:  frame(word(1'($urandom), 7'($urandom_range(0, 25)), 8'($urandom)));
        10: frame(word(1, 7'h1A, ($urandom_range(0, 2) == 0) ? 8'h03 : 8'($urandom)));
        default: begin
          n = $urandom_range(0, 1) ? $urandom_range(4, 15) : $urandom_range(17, 24);
          bad_frame(16'($urandom), n);
        end
      endcase
    end
    frame(word(0, 7'h00, 8'h00));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule